// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block is a hardware master that loads a configuration bitstream into a downstream FPGA over a slave-serial link. A one-cycle `start_i` pulse and a byte count begin a load. The loader first pulses the target's program line. It holds that line until the target's init status reports that the target is in reset, and then releases it. It waits for init to clear again before it sends any data. Bitstream bytes then arrive on a valid/ready stream. Each byte is shifted out on a generated configuration clock, most significant bit first. The target samples each bit on the rising clock edge.

Before each byte is taken, the loader checks the two synchronised status lines. If init is active while done is still low, the target has flagged a CRC failure, and the load stops. After the last byte the data line is held high. The configuration clock keeps toggling until the target raises done. The program-hold wait, the init-clear wait and the final done wait each have their own cycle budget. At the end of a load, `fin_o` pulses for one cycle and `status_o` gives the result.

Back-pressure rules for the byte stream: `s_ready_o` is high only while the loader is waiting for its next byte. A byte is taken on a cycle where both `s_valid_i` and `s_ready_o` are high. The producer may hold `s_valid_i` for as long as it likes, and it may drop `s_valid_i` between bytes. `s_ready_o` does not depend on `s_valid_i`. Once all bytes have been taken, or once the load has stopped, no further byte is taken.

Top module: `serial_cfg_loader`

## Requirements
- R1: On `start_i` while idle, `prog_o` rises in the next cycle. It stays high until the synchronised init reads 1, and it falls one cycle after that.
- R2: After `prog_o` falls, `s_ready_o` stays low until the synchronised init reads 0.
- R3: The program-hold wait, the init-clear wait and the final done wait each last at most `TIMEOUT_CYC` cycles. When one expires, the load ends with `status_o` = 2'b10 and `prog_o`, `cclk_o` and `din_o` low.
- R4: Each byte is sent as eight bits, most significant bit first. The first byte received is the first byte sent.
- R5: For each bit, `cclk_o` falls and `din_o` takes the bit in the same cycle. `cclk_o` stays low for `HALF_DIV` cycles, then high for `HALF_DIV` cycles. `din_o` does not change on a rising edge of `cclk_o`.
- R6: Whenever the loader is ready to take a byte or to enter the final phase, synchronised init = 1 with synchronised done = 0 ends the load with `status_o` = 2'b11. No further byte is taken.
- R7: After the last byte, `din_o` is held at 1 and `cclk_o` toggles every `HALF_DIV` cycles until synchronised done reads 1. The load then ends with `status_o` = 2'b01.
- R8: `s_ready_o` is high only while busy, with bytes still owed, and after the previous byte has been fully shifted out. Exactly `byte_count_i` bytes are taken in a successful load.
- R9: `fin_o` is a one-cycle pulse at the end of each load. `status_o` is nonzero from that cycle on and holds until the next accepted start, which clears it to 2'b00.
- R10: `busy_o` is high from the cycle after an accepted start until the cycle in which `fin_o` pulses. A `start_i` that arrives while busy has no effect.
- R11: `init_i` and `done_i` each pass through two flip-flops before the loader acts on them, so a change has an effect three cycles later.
- R12: With a byte count of zero, the loader goes from the init-clear wait straight to the final done phase, and it takes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a load |
| byte_count_i | input | CNT_W | Number of bitstream bytes, sampled with start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Loader takes the byte this cycle if valid |
| prog_o | output | 1 | Program request to the target, 1 = hold in reset |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data |
| init_i | input | 1 | Target init status, 1 = in reset or error |
| done_i | input | 1 | Target done status, 1 = configured |
| busy_o | output | 1 | Load in progress |
| fin_o | output | 1 | One-cycle end-of-load pulse |
| status_o | output | 2 | 00 none, 01 ok, 10 timeout, 11 CRC error |

## Verification
The embedded properties check the following on every cycle:
- a byte is never offered while program is held;
- data never moves on a rising configuration clock edge;
- the final phase always drives a high data line;
- the end pulse lasts one cycle and carries a nonzero code;
- a detected CRC condition always ends the load in the following cycle.

Only the bench's scenarios can show the bit order and the byte order as the target sees them. The same holds for each timeout's exact cycle budget, the three-cycle status latency, zero-length loads, and a start pulse ignored mid-load. The bench shows these through its cycle-level reference model and by rebuilding the bytes from the rising clock edges.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_CLR,
    ST_FETCH,
    ST_SHIFT,
    ST_POST
  } ld_state_e;

  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_OK      = 2'b01,
    RES_TIMEOUT = 2'b10,
    RES_CRC     = 2'b11
  } ld_result_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_tick.sv
module cfg_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                  cnt_q <= cnt_q + CW'(1);
  end

  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick) else $error("tick without enable"); // R5
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_load_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int HALF_DIV    = 4,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic             prog_o,
  output logic             cclk_o,
  output logic             din_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [1:0]       status_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  ld_state_e        st_q;
  ld_result_e       res_q;
  logic [CNT_W-1:0] rem_q;
  logic [TW-1:0]    wait_q;
  logic [7:0]       sh_q;
  logic [2:0]       bit_q;
  logic             init_s, done_s, tick, crc_err, wait_over;

  cfg_sync #(.W(2), .STAGES(2)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({init_i, done_i}),
    .q     ({init_s, done_s})
  );

  cfg_tick #(.HALF(HALF_DIV)) i_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (st_q == ST_SHIFT || st_q == ST_POST),
    .tick  (tick)
  );

  assign crc_err   = init_s && !done_s;
  assign wait_over = (wait_q == TW'(TIMEOUT_CYC - 1));
  assign s_ready_o = (st_q == ST_FETCH) && !crc_err && (rem_q != '0);
  assign busy_o    = (st_q != ST_IDLE);
  assign status_o  = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      res_q  <= RES_NONE;
      rem_q  <= '0;
      wait_q <= '0;
      sh_q   <= '0;
      bit_q  <= '0;
      prog_o <= 1'b0;
      cclk_o <= 1'b0;
      din_o  <= 1'b0;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          prog_o <= 1'b1;
          rem_q  <= byte_count_i;
          wait_q <= '0;
          res_q  <= RES_NONE;
          st_q   <= ST_PROG;
        end
        ST_PROG: begin
          if (init_s) begin
            prog_o <= 1'b0;
            wait_q <= '0;
            st_q   <= ST_CLR;
          end else if (wait_over) begin
            st_q <= ST_IDLE; fin_o <= 1'b1; res_q <= RES_TIMEOUT;
            prog_o <= 1'b0; cclk_o <= 1'b0; din_o <= 1'b0;
          end else wait_q <= wait_q + TW'(1);
        end
        ST_CLR: begin
          if (!init_s) st_q <= ST_FETCH;
          else if (wait_over) begin
            st_q <= ST_IDLE; fin_o <= 1'b1; res_q <= RES_TIMEOUT;
            prog_o <= 1'b0; cclk_o <= 1'b0; din_o <= 1'b0;
          end else wait_q <= wait_q + TW'(1);
        end
        ST_FETCH: begin
          if (crc_err) begin
            st_q <= ST_IDLE; fin_o <= 1'b1; res_q <= RES_CRC;
            prog_o <= 1'b0; cclk_o <= 1'b0; din_o <= 1'b0;
          end else if (rem_q == '0) begin
            din_o  <= 1'b1;
            wait_q <= '0;
            st_q   <= ST_POST;
          end else if (s_valid_i) begin
            sh_q   <= s_data_i;
            bit_q  <= '0;
            rem_q  <= rem_q - CNT_W'(1);
            cclk_o <= 1'b0;
            din_o  <= s_data_i[7];
            st_q   <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (tick) begin
          if (!cclk_o) cclk_o <= 1'b1;
          else if (bit_q == 3'd7) st_q <= ST_FETCH;
          else begin
            bit_q  <= bit_q + 3'd1;
            sh_q   <= {sh_q[6:0], 1'b0};
            cclk_o <= 1'b0;
            din_o  <= sh_q[6];
          end
        end
        ST_POST: begin
          if (done_s) begin
            st_q <= ST_IDLE; fin_o <= 1'b1; res_q <= RES_OK;
            prog_o <= 1'b0; cclk_o <= 1'b0; din_o <= 1'b0;
          end else if (wait_over) begin
            st_q <= ST_IDLE; fin_o <= 1'b1; res_q <= RES_TIMEOUT;
            prog_o <= 1'b0; cclk_o <= 1'b0; din_o <= 1'b0;
          end else begin
            wait_q <= wait_q + TW'(1);
            if (tick) cclk_o <= !cclk_o;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_READY_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> !s_ready_o) else $error("byte offered during program"); // R2
  AST_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> busy_o) else $error("ready while idle"); // R8
  AST_DIN_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(din_o)) else $error("data moved on rising clock"); // R5
  AST_POST_DIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POST) |-> din_o) else $error("data low in final phase"); // R7
  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o) else $error("end pulse too long"); // R9
  AST_FIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> (status_o != 2'b00)) else $error("end without code"); // R9
  AST_CRC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && crc_err) |=> (fin_o && status_o == 2'b11)) else $error("CRC not reported"); // R6
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && status_o == 2'b10) |-> (!prog_o && !cclk_o)) else $error("lines held after timeout"); // R3
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && prog_o)) else $error("start not taken"); // R10
endmodule

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;
  localparam int CNT_W = 16;
  localparam int HALF  = 2;
  localparam int TO    = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] byte_count_i = '0;
  logic s_valid_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic init_i = 1'b0, done_i = 1'b0;
  logic s_ready_o, prog_o, cclk_o, din_o, busy_o, fin_o;
  logic [1:0] status_o;

  serial_cfg_loader #(.CNT_W(CNT_W), .HALF_DIV(HALF), .TIMEOUT_CYC(TO)) i_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .prog_o(prog_o), .cclk_o(cclk_o), .din_o(din_o), .init_i(init_i), .done_i(done_i),
    .busy_o(busy_o), .fin_o(fin_o), .status_o(status_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 0, all_done = 0, fin_seen = 0, prev_cclk = 0;
  int rise_cnt = 0, n_acc = 0, cur_n = 0;
  logic [7:0] capb;
  logic [7:0] cap[$];
  logic [7:0] sent[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  int ms = 0, mprog = 0, mcclk = 0, mdin = 0, mbit = 0, mrem = 0, mstat = 0, mfin = 0;
  int mtc = 0, mwc = 0, mi1 = 0, mi2 = 0, md1 = 0, md2 = 0;
  logic [7:0] msh = '0;

  task automatic m_end(input int code);
    ms = 0; mfin = 1; mstat = code; mprog = 0; mcclk = 0; mdin = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mprog = 0; mcclk = 0; mdin = 0; mbit = 0; mrem = 0; mstat = 0; mfin = 0;
      mtc = 0; mwc = 0; mi1 = 0; mi2 = 0; md1 = 0; md2 = 0; msh = '0;
    end else begin
      bit crc, en, tk;
      int ntc;
      crc = (mi2 == 1) && (md2 == 0);
      en  = (ms == 4) || (ms == 5);
      tk  = en && (mtc == HALF - 1);
      ntc = (en && !tk) ? mtc + 1 : 0;
      mfin = 0;
      case (ms)
        0: if (start_i) begin mprog = 1; mrem = int'(byte_count_i); ms = 1; mwc = 0; mstat = 0; end
        1: if (mi2 == 1) begin mprog = 0; ms = 2; mwc = 0; end
           else if (mwc == TO - 1) m_end(2); else mwc++;
        2: if (mi2 == 0) ms = 3; else if (mwc == TO - 1) m_end(2); else mwc++;
        3: if (crc) m_end(3);
           else if (mrem == 0) begin ms = 5; mdin = 1; mwc = 0; end
           else if (s_valid_i) begin
             msh = s_data_i; mbit = 0; mrem--; ms = 4; mcclk = 0; mdin = int'(msh[7]);
           end
        4: if (tk) begin
             if (mcclk == 0) mcclk = 1;
             else if (mbit == 7) ms = 3;
             else begin mbit++; msh = msh << 1; mcclk = 0; mdin = int'(msh[7]); end
           end
        5: if (md2 == 1) m_end(1);
           else if (mwc == TO - 1) m_end(2);
           else begin mwc++; if (tk) mcclk = (mcclk == 0) ? 1 : 0; end
        default: ms = 0;
      endcase
      mtc = ntc;
      mi2 = mi1; mi1 = int'(init_i);
      md2 = md1; md1 = int'(done_i);
    end
  end

  // compare model and design, and observe the serial link, away from the edge
  always @(negedge clk) begin
    if (cmp_en) begin
      int erdy;
      erdy = (ms == 3 && !(mi2 == 1 && md2 == 0) && mrem != 0) ? 1 : 0;
      chk("R1 R11 prog", int'(prog_o), mprog);
      chk("R2 R8 ready", int'(s_ready_o), erdy);
      chk("R5 cclk", int'(cclk_o), mcclk);
      chk("R4 R7 din", int'(din_o), mdin);
      chk("R10 busy", int'(busy_o), (ms != 0) ? 1 : 0);
      chk("R9 fin", int'(fin_o), mfin);
      chk("R9 R3 R6 status", int'(status_o), mstat);
      if (cclk_o && !prev_cclk) begin
        rise_cnt++;
        if (rise_cnt <= 8 * cur_n) begin
          capb = {capb[6:0], din_o};
          if (rise_cnt % 8 == 0) cap.push_back(capb);
        end
      end
      prev_cclk = cclk_o;
      if (fin_o) fin_seen = 1;
    end
  end

  task automatic target(input int d_on, input int d_off, input int post_rises, input int crc_after);
    init_i = 0; done_i = 0;
    while (!prog_o && !fin_seen) @(negedge clk);
    if (d_on >= 0 && !fin_seen) begin
      repeat (d_on) @(negedge clk);
      init_i = 1;
      while (prog_o && !fin_seen) @(negedge clk);
      if (d_off >= 0 && !fin_seen) begin
        repeat (d_off) @(negedge clk);
        init_i = 0;
        if (crc_after >= 0) begin
          while (n_acc < crc_after && !fin_seen) @(negedge clk);
          init_i = 1;
        end else if (post_rises >= 0) begin
          while (rise_cnt < 8 * cur_n + post_rises && !fin_seen) @(negedge clk);
          done_i = 1;
        end
      end
    end
    while (!fin_seen) @(negedge clk);
    @(negedge clk);
    init_i = 0; done_i = 0;
  endtask

  task automatic feed(input int n, input bit poke);
    for (int k = 0; k < n; k++) begin
      if (fin_seen) break;
      if (k % 2 == 1) @(negedge clk);
      s_valid_i = 1; s_data_i = sent[k];
      while (1) begin
        if (s_ready_o) begin n_acc++; @(negedge clk); break; end
        if (fin_seen) break;
        @(negedge clk);
      end
      s_valid_i = 0;
      if (poke && k == 0) begin
        start_i = 1; byte_count_i = 16'd7;
        @(negedge clk);
        start_i = 0;
      end
    end
    s_valid_i = 0;
  endtask

  task automatic run(input string tag, input int n, input int d_on, input int d_off,
                     input int post_rises, input int crc_after, input int exp_stat,
                     input int exp_bytes, input bit poke, input int seed);
    sent.delete(); cap.delete();
    for (int k = 0; k < n; k++) sent.push_back(8'((k * 37 + seed) ^ 8'hA5));
    rise_cnt = 0; n_acc = 0; fin_seen = 0; cur_n = n;
    @(negedge clk);
    start_i = 1; byte_count_i = CNT_W'(n);
    @(negedge clk);
    start_i = 0;
    fork
      target(d_on, d_off, post_rises, crc_after);
      feed(n, poke);
    join
    @(negedge clk);
    chk({tag, " status"}, int'(status_o), exp_stat);
    chk({tag, " R8 bytes taken"}, n_acc, exp_bytes);
    chk({tag, " R4 bytes seen"}, cap.size(), exp_bytes);
    for (int k = 0; k < exp_bytes && k < cap.size(); k++)
      chk({tag, " R4 byte value"}, int'(cap[k]), int'(sent[k]));
    chk({tag, " R10 idle after"}, int'(busy_o), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset prog", int'(prog_o), 0);
    chk("R10 reset busy", int'(busy_o), 0);
    chk("R8 reset ready", int'(s_ready_o), 0);
    chk("R5 reset cclk", int'(cclk_o), 0);
    chk("R9 reset fin/status", int'({fin_o, status_o}), 0);
    cmp_en = 1;
    run("R7 normal",         3,  3,  4,  4, -1, 1, 3, 0, 1);
    run("R3 init never",     2, -1,  0,  0, -1, 2, 0, 0, 2);
    run("R3 init stuck",     2,  2, -1,  0, -1, 2, 0, 0, 3);
    run("R6 crc",            3,  2,  2,  0,  1, 3, 1, 0, 4);
    run("R3 done never",     2,  2,  2, -1, -1, 2, 2, 0, 5);
    run("R12 zero count",    0,  1,  1,  0, -1, 1, 0, 0, 6);
    run("R10 start ignored", 2,  4,  3,  6, -1, 1, 2, 1, 7);
    run("R7 one byte",       1,  0,  0,  1, -1, 1, 1, 0, 8);
    all_done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !all_done) begin
      all_done = 1;
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule